// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It takes frame bytes from a byte stream with valid and last markers. It writes them into a ring of fixed 128-byte buffers in system memory. Each buffer is described by an 8-byte descriptor at `base + 8*i`. Offset 0 holds the address word: the buffer address, a free/owned flag in bit 0 and an end-of-ring flag in bit 1. Offset 4 holds the status word, which the engine writes.

Before it fills a buffer, the engine reads the address word over a single memory-master port. Software must have cleared bit 0. A frame longer than one buffer spreads over consecutive descriptors and wraps past the end-of-ring descriptor back to the base. When a buffer is complete, the engine writes its status word and then hands the buffer back by writing the address word with bit 0 set. If the descriptor it needs is still held by software, the rest of the frame is discarded and a sticky flag is raised. Software loads the ring base through a write strobe. That write also rewinds the descriptor pointer and clears the flag.

Top module: `rx_ring_writer`

## Requirements
- R1: Right after reset, `mem_req_o`, `rx_ready_o` and `bna_o` are all low.
- R2: Descriptor `i` sits at `base + 8*i`, where `base` is 8-byte aligned. The buffer address is the address word with its low 7 bits cleared. Byte `k` of a buffer is written as one write to word address `(buf + k) & ~3`, with byte enable `1 << ((buf + k) & 3)` and the byte repeated on all four lanes.
- R3: The engine fills a buffer only if bit 0 of its address word reads 0. Once the buffer is done, it writes the status word at offset 4 with all byte enables. On the next cycle it writes the address word back unchanged except that bit 0 is set.
- R4: After a descriptor whose address word has bit 1 set, the next descriptor is the ring base. A frame may run across that wrap without a break.
- R5: In the buffer that ends a frame, status bits 11:0 hold the total frame length in bytes. In every other buffer they are 0.
- R6: Status bit 14 is set only in the first buffer of a frame. Status bit 15 is set only in the last.
- R7: `rx_flags_i` is sampled when a frame starts and copied into the status word of every buffer of that frame. Bit 0 goes to status bit 22, bits 4:1 to status bits 26:23, and bit 5 to status bit 31. All other status bits are 0.
- R8: If the descriptor needed next still has bit 0 set, the engine makes no further memory writes for that frame. It accepts and discards the remaining bytes up to the last one, and sets `bna_o`. `bna_o` stays set. The next frame tries the same descriptor again.
- R9: A pulse on `base_we_i` loads `base_i`, points the engine at descriptor 0 and clears `bna_o` on the next cycle.
- R10: A frame that ends part-way through a buffer still consumes that whole buffer. The next frame starts in the following descriptor.
- R11: `rx_ready_o` is high only while a buffer is being filled or a frame is being discarded. A byte is taken on a clock edge where both `rx_valid_i` and `rx_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Ring base write strobe |
| base_i | input | AW | Ring base address, 8-byte aligned |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_flags_i | input | 6 | Match flags of the current frame |
| rx_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables of a write |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| bna_o | output | 1 | Sticky flag: a needed buffer was not available |

## Verification
If the descriptor pointer goes wrong, the very next buffer write lands at the wrong address. That shows in the first mismatching memory write, within a few cycles of the frame start. If the ownership decision goes wrong, either writes appear for a frame that should have been discarded, or writes go missing and the expected queue stalls. A corrupted length or buffer counter shows in the status word written one cycle after the last byte, or in a status write coming early or late. The scoreboard compares every memory write in order, so each of these faults is caught at the first write it disturbs.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_FILL, S_STAT, S_OWN, S_DROP
  } rxr_state_e;

  localparam int FLAG_W   = 6;
  localparam int OWN_BIT  = 0;
  localparam int END_BIT  = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;
  localparam int TID_BIT  = 22;
  localparam int AM_LSB   = 23;
  localparam int BC_BIT   = 31;
  localparam int STAT_OFS = 4;
endpackage

// File: rtl/rxr_desc_ptr.sv
module rxr_desc_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_o  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      ptr_o  <= base_i;
    end else if (adv_i) begin
      ptr_o <= wrap_i ? base_q : ptr_o + AW'(DESC_BYTES);
    end
  end

  p_wrap_to_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && !load_i) |=> (ptr_o == base_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i && !load_i) |=> (ptr_o == $past(ptr_o) + AW'(DESC_BYTES)));
  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_o == $past(base_i)));
endmodule

// File: rtl/rxr_fill_ctr.sv
module rxr_fill_ctr #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12,
  localparam int OFF_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_frame_i,
  input  logic             clr_buf_i,
  input  logic             inc_i,
  output logic [OFF_W-1:0] off_o,
  output logic [LEN_W-1:0] len_o,
  output logic             full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o <= '0;
      len_o <= '0;
    end else begin
      if (clr_buf_i)  off_o <= '0;
      else if (inc_i) off_o <= off_o + 1'b1;
      if (clr_frame_i) len_o <= '0;
      else if (inc_i)  len_o <= len_o + 1'b1;
    end
  end

  assign full_o = (off_o == OFF_W'(BUF_BYTES - 1));

  p_len_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_frame_i) |=> (len_o == $past(len_o) + 1'b1));
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [31:0]       word_o
);
  always_comb begin
    word_o = '0;
    if (eof_i) word_o[LEN_W-1:0] = len_i;
    word_o[SOF_BIT]          = sof_i;
    word_o[EOF_BIT]          = eof_i;
    word_o[TID_BIT]          = flags_i[0];
    word_o[AM_LSB +: 4]      = flags_i[4:1];
    word_o[BC_BIT]           = flags_i[5];
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BUF_BYTES  = 128,
  parameter int LEN_W      = 12,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic [FLAG_W-1:0] rx_flags_i,
  output logic              rx_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              bna_o
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  rxr_state_e        state_q, state_d;
  logic [AW-1:0]     buf_q, ptr, byte_addr;
  logic [31:0]       aword_q, stat_word;
  logic              wrap_q, first_q, eof_q, bna_q;
  logic [FLAG_W-1:0] flags_q;
  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  len;
  logic              full, take, start, adv, clr_buf;

  assign take    = rx_valid_i && rx_ready_o;
  assign start   = (state_q == S_IDLE) && rx_valid_i;
  assign adv     = (state_q == S_OWN);
  assign clr_buf = (state_q == S_CHECK);

  rxr_desc_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(base_we_i), .base_i(base_i),
    .adv_i (adv), .wrap_i(wrap_q), .ptr_o(ptr)
  );

  rxr_fill_ctr #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_frame_i(start), .clr_buf_i(clr_buf),
    .inc_i ((state_q == S_FILL) && take), .off_o(off), .len_o(len), .full_o(full)
  );

  rxr_status_fmt #(.LEN_W(LEN_W)) u_fmt (
    .sof_i(first_q), .eof_i(eof_q), .len_i(len), .flags_i(flags_q), .word_o(stat_word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (rx_valid_i) state_d = S_FETCH;
      S_FETCH: state_d = S_CHECK;
      S_CHECK: state_d = mem_rdata_i[OWN_BIT] ? S_DROP : S_FILL;
      S_FILL:  if (take && (rx_last_i || full)) state_d = S_STAT;
      S_STAT:  state_d = S_OWN;
      S_OWN:   state_d = eof_q ? S_IDLE : S_FETCH;
      S_DROP:  if (take && rx_last_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
      aword_q <= '0;
      wrap_q  <= 1'b0;
      first_q <= 1'b0;
      eof_q   <= 1'b0;
      flags_q <= '0;
      bna_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        first_q <= 1'b1;
        flags_q <= rx_flags_i;
      end
      if (state_q == S_CHECK && !mem_rdata_i[OWN_BIT]) begin
        aword_q <= mem_rdata_i;
        buf_q   <= {mem_rdata_i[AW-1:OFF_W], OFF_W'(0)};
        wrap_q  <= mem_rdata_i[END_BIT];
      end
      if (state_q == S_FILL && take) eof_q <= rx_last_i;
      if (state_q == S_OWN) first_q <= 1'b0;
      if (base_we_i) bna_q <= 1'b0;
      else if (state_q == S_CHECK && mem_rdata_i[OWN_BIT]) bna_q <= 1'b1;
    end
  end

  assign byte_addr  = buf_q | AW'(off);
  assign rx_ready_o = (state_q == S_FILL) || (state_q == S_DROP);
  assign bna_o      = bna_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_be_o    = 4'h0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH: mem_req_o = 1'b1;
      S_FILL: begin
        mem_req_o   = rx_valid_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = {byte_addr[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << byte_addr[1:0];
        mem_wdata_o = {4{rx_data_i}};
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + AW'(STAT_OFS);
        mem_be_o    = 4'hF;
        mem_wdata_o = stat_word;
      end
      S_OWN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'hF;
        mem_wdata_o = aword_q | 32'h1;
      end
      default: ;
    endcase
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!mem_req_o && !rx_ready_o));
  p_own_after_stat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o == 4'hF && mem_addr_o[2])
      |=> (mem_req_o && mem_we_o && mem_wdata_o[OWN_BIT] && !mem_addr_o[2]));
  p_owned_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && mem_rdata_i[OWN_BIT]) |=> !mem_req_o);
  p_len_only_eof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_addr_o[2] && mem_be_o == 4'hF && !mem_wdata_o[EOF_BIT])
      |-> (mem_wdata_o[LEN_W-1:0] == '0));
  p_bna_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bna_o && !base_we_i) |=> bna_o);
  p_bna_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> !bna_o);
  p_ready_states_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> $onehot0({mem_req_o && !mem_we_o, mem_be_o == 4'hF}));
endmodule

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int AW = 32;
  localparam int N = 4;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] BUFB = 32'h100;

  logic clk = 0, rst_n = 0;
  logic base_we = 0;
  logic [AW-1:0] base = '0;
  logic rx_valid = 0, rx_last = 0;
  logic [7:0] rx_data = '0;
  logic [5:0] rx_flags = '0;
  logic rx_ready, mem_req, mem_we, bna;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mem [0:255];
  logic [31:0] q_addr[$], q_data[$];
  logic [3:0]  q_be[$];
  string       q_tag[$];
  bit m_own[N];
  logic [31:0] m_aw[N];
  int m_ptr = 0;
  bit m_bna = 0;

  always #4 clk = ~clk;

  rx_ring_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .base_i(base),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .rx_flags_i(rx_flags), .rx_ready_o(rx_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .bna_o(bna)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && mem_req && mem_we) begin
      if (q_addr.size() == 0) begin
        check(0, "R8 unexpected write", mem_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea, ed, mask;
        logic [3:0] eb;
        string t;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        eb = q_be.pop_front(); t = q_tag.pop_front();
        mask = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
        check(mem_addr == ea, {t, " addr"}, mem_addr, ea);
        check(mem_be == eb, {t, " be"}, {28'd0, mem_be}, {28'd0, eb});
        check((mem_wdata & mask) == (ed & mask), {t, " data"}, mem_wdata & mask, ed & mask);
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [3:0] b, input logic [31:0] d, input string t);
    q_addr.push_back(a); q_be.push_back(b); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic release_desc(input int i);
    m_own[i] = 0;
    mem[(BASE + 8*i) >> 2] = m_aw[i];
  endtask

  task automatic write_base();
    @(negedge clk); base_we = 1; base = BASE;
    @(negedge clk); base_we = 0;
    m_ptr = 0; m_bna = 0;
    @(negedge clk);
    check(bna == 0, "R9 bna cleared", {31'd0, bna}, 0);
  endtask

  task automatic send_frame(input int len, input int seed, input logic [5:0] fl);
    int idx = m_ptr, rem = len, off = 0;
    bit first = 1;
    while (rem > 0) begin
      int n;
      bit last;
      logic [31:0] st, ba;
      if (m_own[idx]) begin m_bna = 1; break; end
      n = (rem > 128) ? 128 : rem;
      last = (rem == n);
      ba = BUFB + 128*idx;
      for (int k = 0; k < n; k++) begin
        logic [31:0] a;
        logic [7:0] by;
        a = ba + k; by = 8'(seed + off + k);
        push({a[31:2], 2'b00}, 4'b0001 << a[1:0], {4{by}}, "R2 byte");
      end
      st = '0;
      if (last) st[11:0] = 12'(len);
      st[14] = first; st[15] = last;
      st[22] = fl[0]; st[26:23] = fl[4:1]; st[31] = fl[5];
      push(BASE + 8*idx + 4, 4'hF, st, "R5/R6/R7 status");
      push(BASE + 8*idx, 4'hF, m_aw[idx] | 32'h1, "R3 own");
      m_own[idx] = 1;
      idx = (idx == N-1) ? 0 : idx + 1;
      off += n; rem -= n; first = 0;
    end
    m_ptr = idx;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + k); rx_last = (k == len-1); rx_flags = fl;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    while (q_addr.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(bna == m_bna, "R8 bna", {31'd0, bna}, {31'd0, m_bna});
    check(rx_ready == 0, "R11 ready idle", {31'd0, rx_ready}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < N; i++) begin
      m_aw[i] = BUFB + 128*i;
      if (i == N-1) m_aw[i][1] = 1'b1;
      m_own[i] = 0;
    end
    m_aw[2][3:2] = 2'b11; // R2: low bits ignored for buffer address
    for (int i = 0; i < N; i++) mem[(BASE + 8*i) >> 2] = m_aw[i];
    repeat (3) @(negedge clk);
    check(mem_req == 0, "R1 req", {31'd0, mem_req}, 0);
    check(rx_ready == 0, "R1 ready", {31'd0, rx_ready}, 0);
    check(bna == 0, "R1 bna", {31'd0, bna}, 0);
    rst_n = 1;
    write_base();
    send_frame(60, 1, 6'b100001);    // R10: partial buffer
    send_frame(200, 7, 6'b011110);   // R10: starts at next descriptor
    release_desc(0); release_desc(1); release_desc(2);
    send_frame(300, 3, 6'b000100);   // R4: wraps d3 -> d0 -> d1
    send_frame(128, 9, 6'b100000);   // exact buffer
    send_frame(50, 5, 6'b000000);    // R8: d3 owned, dropped
    release_desc(3);
    send_frame(10, 11, 6'b010101);   // R8: retry same descriptor
    write_base();                    // R9
    release_desc(0);
    send_frame(200, 13, 6'b111111);  // R8: mid-frame drop at d1
    write_base();                    // R9
    for (int i = 0; i < N; i++) release_desc(i);
    send_frame(5, 17, 6'b000010);    // R9: pointer back at d0
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule